// File: doc/BRIEF.md
# Rotating-Parity Stripe Mapper with XOR Rebuild

This block serves a four-disk array. Each stripe in the array holds three data blocks and one parity block. The position of the parity block moves from one stripe to the next, so no single disk carries all the parity writes.

The block has two parts:

- **Address mapper.** It takes a logical block number and divides it by three with a bit-serial divider. When the division completes, it reports three things:
  - the stripe row;
  - the disk that holds the data block;
  - the disk that holds that row's parity.
- **XOR stream datapath.** It receives 32-bit words, each tagged with its source disk, and folds them into a running XOR.
  - With no disk marked failed, the three data words of a stripe position produce the parity word.
  - With one disk marked failed, words tagged with that disk are dropped. The three surviving words then regenerate the missing word, and the result is flagged as rebuilt.

Both parts share the failed-disk mask. The array tolerates at most one failed disk, so the block refuses any mapping request or stream group while two or more mask bits are set.

Stream rules are as follows:

- **Input.** A word moves on a cycle where `in_valid` and `in_ready` are both high. `in_last` marks the closing word of a group.
- **Output.** The result is a single word. `out_valid` stays high and `out_data` stays unchanged until `out_ready` is seen high at a clock edge.
- **Back-pressure.** While a result waits to be taken, `in_ready` is low, so the next group stalls upstream.
- **Result latency.** The result, or the error pulse, appears in the cycle after the closing word is accepted.

Top module: `parity_stripe_engine`

## Requirements
- R1: A mapping started by `req_start` while `map_busy` is low gives `map_row` = lba div 3. `map_valid` pulses for one cycle only after `map_busy` has been high for the division. `map_row` keeps its value until the next mapping.
- R2: `map_par_disk` = 3 − (row mod 4). So the parity disk is 3 in row 0, 2 in row 1 and 1 in row 2, wrapping to 3 in row 4.
- R3: The data slot is lba mod 3. Slots 0, 1 and 2 fill the three non-parity disks in ascending disk index. For example, in row 1 (parity on disk 2), slot 2 lands on disk 3.
- R4: A `req_start` while two or more `fail_mask` bits are set gives a one-cycle `map_reject` and no `map_valid`.
- R5: With `fail_mask` = 0, a group of exactly three words yields `out_data` equal to the XOR of those words, with `out_rebuilt` = 0 and `out_last` = 1.
- R6: With exactly one `fail_mask` bit set, a word whose `in_disk` names that bit is accepted but does not enter the XOR or the count. The output is the XOR of the three survivors, with `out_rebuilt` = 1.
- R7: A group whose counted words number other than three gives a one-cycle `stream_err` and no output word. The accumulator restarts from zero for the next group.
- R8: A group closed while two or more `fail_mask` bits are set gives `stream_err` and no output word.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high, `out_data` is held, and `in_ready` is low.
- R10: After reset, `out_valid`, `map_valid`, `map_reject`, `stream_err` and `map_busy` are 0, and `in_ready` is 1.
- R11: A `req_start` while `map_busy` is high is ignored. The running mapping finishes with its original result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fail_mask | input | 4 | Failed-disk mask, bit i = disk i |
| req_start | input | 1 | Start a mapping |
| req_lba | input | LBA_W | Logical block number |
| map_busy | output | 1 | Division in progress |
| map_valid | output | 1 | One-cycle pulse: mapping ready |
| map_reject | output | 1 | One-cycle pulse: request refused |
| map_row | output | LBA_W | Stripe row |
| map_disk | output | 2 | Disk holding the data block |
| map_par_disk | output | 2 | Disk holding the row's parity |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word can be taken |
| in_data | input | DATA_W | Input word |
| in_disk | input | 2 | Source disk of the input word |
| in_last | input | 1 | Closing word of a group |
| out_valid | output | 1 | Result word valid |
| out_ready | input | 1 | Consumer takes result |
| out_data | output | DATA_W | Parity or rebuilt word |
| out_last | output | 1 | Last word of the result |
| out_rebuilt | output | 1 | Result is regenerated data |
| stream_err | output | 1 | One-cycle pulse: group rejected |

## Verification
The hardest situation to reach is degraded mode with the failed disk's word sitting in the middle of a group. If the drop were not honoured, the count would become four and the XOR would be wrong, and both faults would show only in the closing cycle.

The stimulus sends that word between two survivors. It then checks the rebuilt word against a value computed in the bench.

A second hard case is a result held under back-pressure while the next group is already waiting. The stimulus lowers `out_ready` for several cycles and checks that the input stays blocked and the held word does not change.

// File: rtl/stripe_pkg.sv
package stripe_pkg;
  localparam int NDISK   = 4;
  localparam int DISK_W  = $clog2(NDISK);
  localparam int NSLOT   = NDISK - 1;
  localparam int CNT_W   = 3;

  // parity walks down one disk per row
  function automatic logic [DISK_W-1:0] parity_disk_of(input logic [DISK_W-1:0] row_lo);
    return DISK_W'(NDISK - 1) - row_lo;
  endfunction

  // data slots skip over the parity disk, ascending
  function automatic logic [DISK_W-1:0] data_disk_of(input logic [DISK_W-1:0] slot,
                                                     input logic [DISK_W-1:0] pdisk);
    return (slot >= pdisk) ? slot + DISK_W'(1) : slot;
  endfunction
endpackage

// File: rtl/fail_mask_decode.sv
module fail_mask_decode
  import stripe_pkg::*;
(
  input  logic [NDISK-1:0] mask,
  output logic             degraded,
  output logic             multi_fail
);
  logic [DISK_W:0] ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < NDISK; i++) ones = ones + (DISK_W+1)'(mask[i]);
    degraded   = (ones == (DISK_W+1)'(1));
    multi_fail = (ones > (DISK_W+1)'(1));
  end
endmodule

// File: rtl/stripe_addr_map.sv
module stripe_addr_map
  import stripe_pkg::*;
#(
  parameter int LBA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LBA_W-1:0]  lba,
  input  logic              refuse,
  output logic              busy,
  output logic              valid,
  output logic              reject,
  output logic [LBA_W-1:0]  row,
  output logic [DISK_W-1:0] disk,
  output logic [DISK_W-1:0] par_disk
);
  localparam int STEP_W = $clog2(LBA_W + 1);

  logic [LBA_W-1:0]  shift_q, quot_q;
  logic [1:0]        rem_q;
  logic [STEP_W-1:0] step_q;
  logic [2:0]        trial;
  logic              take;
  logic [1:0]        rem_n;
  logic [LBA_W-1:0]  quot_n;
  logic [DISK_W-1:0] pd_n;

  // one restoring step of division by three
  always_comb begin
    trial  = {rem_q, shift_q[LBA_W-1]};
    take   = (trial >= 3'd3);
    rem_n  = take ? 2'(trial - 3'd3) : trial[1:0];
    quot_n = {quot_q[LBA_W-2:0], take};
    pd_n   = parity_disk_of(quot_n[DISK_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      valid    <= 1'b0;
      reject   <= 1'b0;
      shift_q  <= '0;
      quot_q   <= '0;
      rem_q    <= '0;
      step_q   <= '0;
      row      <= '0;
      disk     <= '0;
      par_disk <= '0;
    end else begin
      valid  <= 1'b0;
      reject <= 1'b0;
      if (!busy) begin
        if (start) begin
          if (refuse) begin
            reject <= 1'b1;
          end else begin
            busy    <= 1'b1;
            shift_q <= lba;
            quot_q  <= '0;
            rem_q   <= '0;
            step_q  <= '0;
          end
        end
      end else begin
        shift_q <= {shift_q[LBA_W-2:0], 1'b0};
        quot_q  <= quot_n;
        rem_q   <= rem_n;
        step_q  <= step_q + STEP_W'(1);
        if (step_q == STEP_W'(LBA_W - 1)) begin
          busy     <= 1'b0;
          valid    <= 1'b1;
          row      <= quot_n;
          par_disk <= pd_n;
          disk     <= data_disk_of(rem_n, pd_n);
        end
      end
    end
  end
endmodule

// File: rtl/stripe_xor_accum.sv
module stripe_xor_accum
  import stripe_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NDISK-1:0]  mask,
  input  logic              degraded,
  input  logic              multi_fail,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [DISK_W-1:0] in_disk,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_rebuilt,
  output logic              err
);
  logic [DATA_W-1:0] acc_q, acc_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              beat, counted;

  assign in_ready = !out_valid;

  always_comb begin
    beat    = in_valid && in_ready;
    counted = beat && !mask[in_disk];
    acc_n   = counted ? (acc_q ^ in_data) : acc_q;
    cnt_n   = (counted && cnt_q != '1) ? cnt_q + CNT_W'(1) : cnt_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q       <= '0;
      cnt_q       <= '0;
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_rebuilt <= 1'b0;
      err         <= 1'b0;
    end else begin
      err <= 1'b0;
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (beat) begin
        if (in_last) begin
          acc_q <= '0;
          cnt_q <= '0;
          if (cnt_n == CNT_W'(NSLOT) && !multi_fail) begin
            out_valid   <= 1'b1;
            out_data    <= acc_n;
            out_rebuilt <= degraded;
          end else begin
            err <= 1'b1;
          end
        end else begin
          acc_q <= acc_n;
          cnt_q <= cnt_n;
        end
      end
    end
  end
endmodule

// File: rtl/parity_stripe_engine.sv
module parity_stripe_engine
  import stripe_pkg::*;
#(
  parameter int LBA_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        fail_mask,
  input  logic              req_start,
  input  logic [LBA_W-1:0]  req_lba,
  output logic              map_busy,
  output logic              map_valid,
  output logic              map_reject,
  output logic [LBA_W-1:0]  map_row,
  output logic [1:0]        map_disk,
  output logic [1:0]        map_par_disk,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [1:0]        in_disk,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic              out_rebuilt,
  output logic              stream_err
);
  logic degraded, multi_fail;

  fail_mask_decode u_mask (
    .mask       (fail_mask),
    .degraded   (degraded),
    .multi_fail (multi_fail)
  );

  stripe_addr_map #(.LBA_W(LBA_W)) u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (req_start),
    .lba      (req_lba),
    .refuse   (multi_fail),
    .busy     (map_busy),
    .valid    (map_valid),
    .reject   (map_reject),
    .row      (map_row),
    .disk     (map_disk),
    .par_disk (map_par_disk)
  );

  stripe_xor_accum #(.DATA_W(DATA_W)) u_xor (
    .clk         (clk),
    .rst_n       (rst_n),
    .mask        (fail_mask),
    .degraded    (degraded),
    .multi_fail  (multi_fail),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_data     (in_data),
    .in_disk     (in_disk),
    .in_last     (in_last),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_data    (out_data),
    .out_rebuilt (out_rebuilt),
    .err         (stream_err)
  );

  // the result is always a single word
  assign out_last = out_valid;
endmodule

// File: rtl/stripe_engine_checks.sv
module stripe_engine_checks #(
  parameter int LBA_W  = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              map_busy,
  input logic              map_valid,
  input logic              map_reject,
  input logic [1:0]        map_disk,
  input logic [1:0]        map_par_disk,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              stream_err
);
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R9
  AST_IN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R9
  AST_MAP_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    map_valid |-> $past(map_busy)); // R1
  AST_DATA_NOT_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    map_valid |-> map_disk != map_par_disk); // R3
  AST_REJECT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(map_valid && map_reject)); // R4
  AST_ERR_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    stream_err |-> !$rose(out_valid)); // R7
endmodule

bind parity_stripe_engine stripe_engine_checks #(.LBA_W(LBA_W), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .map_busy     (map_busy),
  .map_valid    (map_valid),
  .map_reject   (map_reject),
  .map_disk     (map_disk),
  .map_par_disk (map_par_disk),
  .in_ready     (in_ready),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_data     (out_data),
  .stream_err   (stream_err)
);

// File: tb/parity_stripe_engine_test.sv
module parity_stripe_engine_test;
  localparam int LBA_W  = 16;
  localparam int DATA_W = 32;
  localparam int NVEC   = 10;

  // {lba, expected row, expected data disk, expected parity disk}
  localparam logic [35:0] MAP_VEC [NVEC] = '{
    {16'd0,     16'd0,     2'd0, 2'd3},
    {16'd2,     16'd0,     2'd2, 2'd3},
    {16'd3,     16'd1,     2'd0, 2'd2},
    {16'd5,     16'd1,     2'd3, 2'd2},
    {16'd7,     16'd2,     2'd2, 2'd1},
    {16'd9,     16'd3,     2'd1, 2'd0},
    {16'd11,    16'd3,     2'd3, 2'd0},
    {16'd12,    16'd4,     2'd0, 2'd3},
    {16'd100,   16'd33,    2'd1, 2'd2},
    {16'd65535, 16'd21845, 2'd0, 2'd2}
  };

  logic              clk = 0;
  logic              rst_n = 0;
  logic [3:0]        fail_mask = '0;
  logic              req_start = 0;
  logic [LBA_W-1:0]  req_lba = '0;
  logic              map_busy, map_valid, map_reject;
  logic [LBA_W-1:0]  map_row;
  logic [1:0]        map_disk, map_par_disk;
  logic              in_valid = 0;
  logic              in_ready;
  logic [DATA_W-1:0] in_data = '0;
  logic [1:0]        in_disk = '0;
  logic              in_last = 0;
  logic              out_valid;
  logic              out_ready = 1;
  logic [DATA_W-1:0] out_data;
  logic              out_last, out_rebuilt, stream_err;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  parity_stripe_engine #(.LBA_W(LBA_W), .DATA_W(DATA_W)) uut (.*);

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      $display("FAIL watchdog: run hung (actual %0d cycles, expected under 20000)", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails + 1);
      $finish;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive a request at a negedge; return at the negedge where map_valid is seen
  task automatic do_map(input logic [15:0] lba, output int waited);
    @(negedge clk);
    req_lba = lba; req_start = 1;
    @(negedge clk);
    req_start = 0;
    waited = 0;
    while (!map_valid && waited < 100) begin
      @(negedge clk);
      waited++;
    end
  endtask

  task automatic send(input logic [31:0] d, input logic [1:0] dk, input logic last);
    @(negedge clk);
    in_valid = 1; in_data = d; in_disk = dk; in_last = last;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0; in_last = 0;
  endtask

  initial begin
    int w;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 out_valid", 64'(out_valid), 64'd0);
    check("R10 map_valid", 64'(map_valid), 64'd0);
    check("R10 map_busy", 64'(map_busy), 64'd0);
    check("R10 stream_err", 64'(stream_err), 64'd0);
    check("R10 in_ready", 64'(in_ready), 64'd1);
    rst_n = 1;

    for (int i = 0; i < NVEC; i++) begin
      do_map(MAP_VEC[i][35:20], w);
      check("R1 map_valid seen", 64'(map_valid), 64'd1);
      check("R1 row", 64'(map_row), 64'(MAP_VEC[i][19:4]));
      check("R3 data disk", 64'(map_disk), 64'(MAP_VEC[i][3:2]));
      check("R2 parity disk", 64'(map_par_disk), 64'(MAP_VEC[i][1:0]));
    end

    // R1 map_valid is a single-cycle pulse and the row holds
    @(negedge clk);
    check("R1 pulse width", 64'(map_valid), 64'd0);
    check("R1 row holds", 64'(map_row), 64'd21845);

    // R11 start ignored while busy
    @(negedge clk);
    req_lba = 16'd30; req_start = 1;
    @(negedge clk);
    req_lba = 16'd8;
    check("R11 busy", 64'(map_busy), 64'd1);
    @(negedge clk);
    req_start = 0;
    w = 0;
    while (!map_valid && w < 100) begin @(negedge clk); w++; end
    check("R11 row from first request", 64'(map_row), 64'd10);
    check("R11 disk", 64'(map_disk), 64'd0);
    check("R11 parity", 64'(map_par_disk), 64'd1);

    // R4 reject with two failed disks
    fail_mask = 4'b0101;
    @(negedge clk);
    req_lba = 16'd4; req_start = 1;
    @(negedge clk);
    req_start = 0;
    check("R4 reject", 64'(map_reject), 64'd1);
    check("R4 not busy", 64'(map_busy), 64'd0);
    repeat (20) begin
      @(negedge clk);
      if (map_valid) check("R4 no map_valid", 64'd1, 64'd0);
    end
    fail_mask = 4'b0000;

    // R5 normal parity generation
    send(32'hA5A5_0001, 2'd0, 0);
    send(32'h1234_5678, 2'd1, 0);
    send(32'h0F0F_F0F0, 2'd2, 1);
    check("R5 out_valid", 64'(out_valid), 64'd1);
    check("R5 parity", 64'(out_data), 64'(32'hA5A5_0001 ^ 32'h1234_5678 ^ 32'h0F0F_F0F0));
    check("R5 rebuilt", 64'(out_rebuilt), 64'd0);
    check("R5 last", 64'(out_last), 64'd1);

    // R6 degraded: failed disk word in the middle is dropped
    fail_mask = 4'b0100;
    send(32'h1111_0000, 2'd0, 0);
    send(32'hDEAD_BEEF, 2'd2, 0);
    send(32'h0000_2222, 2'd1, 0);
    send(32'h4444_4444, 2'd3, 1);
    check("R6 out_valid", 64'(out_valid), 64'd1);
    check("R6 rebuilt data", 64'(out_data), 64'(32'h1111_0000 ^ 32'h0000_2222 ^ 32'h4444_4444));
    check("R6 rebuilt flag", 64'(out_rebuilt), 64'd1);
    fail_mask = 4'b0000;

    // R7 short group
    send(32'h0000_0001, 2'd0, 0);
    send(32'h0000_0002, 2'd1, 1);
    check("R7 err", 64'(stream_err), 64'd1);
    check("R7 no output", 64'(out_valid), 64'd0);
    // R7 long group
    send(32'h1, 2'd0, 0);
    send(32'h2, 2'd1, 0);
    send(32'h4, 2'd2, 0);
    send(32'h8, 2'd3, 1);
    check("R7 err long", 64'(stream_err), 64'd1);
    check("R7 no output long", 64'(out_valid), 64'd0);
    // R7 restart clean after error
    send(32'h10, 2'd0, 0);
    send(32'h20, 2'd1, 0);
    send(32'h40, 2'd3, 1);
    check("R7 restart value", 64'(out_data), 64'h70);

    // R8 two failed disks on a stream group
    fail_mask = 4'b0011;
    send(32'h1, 2'd2, 0);
    send(32'h2, 2'd3, 0);
    send(32'h4, 2'd0, 1);
    check("R8 err", 64'(stream_err), 64'd1);
    check("R8 no output", 64'(out_valid), 64'd0);
    fail_mask = 4'b0000;

    // R9 back-pressure
    out_ready = 0;
    send(32'hCAFE_0000, 2'd0, 0);
    send(32'h0000_BABE, 2'd1, 0);
    send(32'h0101_0101, 2'd2, 1);
    in_valid = 1; in_data = 32'hFFFF_FFFF; in_disk = 2'd0; in_last = 0;
    repeat (3) @(negedge clk);
    check("R9 held valid", 64'(out_valid), 64'd1);
    check("R9 held data", 64'(out_data), 64'(32'hCAFE_0000 ^ 32'h0000_BABE ^ 32'h0101_0101));
    check("R9 in blocked", 64'(in_ready), 64'd0);
    in_valid = 0;
    out_ready = 1;
    @(negedge clk);
    check("R9 released", 64'(out_valid), 64'd0);
    // blocked word must not have entered the accumulator
    send(32'h3, 2'd0, 0);
    send(32'h5, 2'd1, 0);
    send(32'h9, 2'd2, 1);
    check("R9 blocked word not taken", 64'(out_data), 64'hF);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule